// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level, forward-mapped page table held in memory. A start request captures the virtual address together with a table base value. The walker then makes two dependent reads on a synchronous memory port. The first read fetches an entry from the first-level table. That entry holds the base of a second-level table, and the second read indexes that table to obtain a frame number. The walker reports the result with a single-cycle done pulse, carrying either a physical address or a fault with the level at which the walk stopped.

The virtual address has three fields. The top index selects the first-level entry and the middle index selects the second-level entry. The low offset passes through to the physical address unchanged. Every table entry carries a valid flag in its most significant bit. A cleared flag at either level stops the walk, and no further reads are made. Each translation therefore costs one memory read per table level before the data access can start.

Top module: `pt_walker`

## Requirements
- R1: After reset, and until a start is accepted, `busy_o`, `mem_req_o` and `done_o` are low.
- R2: In the first cycle after a start is accepted in the idle state, `mem_req_o` is high and `mem_addr_o` equals the captured table base plus the top index (virtual address bits 19..16), taken modulo 2^12.
- R3: When the first-level read data has bit 15 set, the next cycle issues a second read at the entry's bits 11..0 plus the middle index (virtual address bits 15..10), taken modulo 2^12.
- R4: When the first-level read data has bit 15 clear, no second read is issued, and the walk ends with `fault_o` high and `fault_lvl_o` low.
- R5: When the second-level read data has bit 15 clear, the walk ends with `fault_o` high and `fault_lvl_o` high.
- R6: `done_o` is a one-cycle pulse in the third cycle after the start is accepted, and the walker is idle in the following cycle.
- R7: The virtual address and table base are captured when the start is accepted. Start requests and input changes made while busy have no effect on the walk or its result.
- R8: `busy_o` is high from the cycle after acceptance through the done cycle, and memory reads occur only while busy.
- R9: On a successful walk, `paddr_o` equals the second-level entry bits 5..0 followed by virtual address bits 9..0, with `fault_o` low. `paddr_o`, `fault_o` and `fault_lvl_o` are zero whenever `done_o` is low, and `paddr_o` is zero on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a translation (accepted only when idle) |
| vaddr_i | input | 20 | Virtual address to translate |
| ptbr_i | input | 12 | Word address of the first-level table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 12 | Memory word address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the request |
| done_o | output | 1 | Result pulse |
| fault_o | output | 1 | Translation failed |
| fault_lvl_o | output | 1 | Failing level: 0 first, 1 second |
| paddr_o | output | 16 | Physical address (frame and offset) |

## Verification
The bench builds the walker with its default parameters: a 4-bit and a 6-bit index, a 10-bit offset, 12-bit word addresses, 16-bit entries and 6-bit frames. With these values a complete 4096-word table memory fits in the bench and can be filled at random. Random walks then reach both valid and invalid entries at each level, and random bases reach the wrap of both index adders. Directed walks add the all-ones address with the largest base, a fault at each level, and a walk in which the start and address inputs keep toggling while the walker is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_L1 = 2'd1,
    ST_READ_L2 = 2'd2,
    ST_DONE    = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int P1_W  = 4,
  parameter int P2_W  = 6,
  parameter int OFF_W = 10,
  localparam int VA_W = P1_W + P2_W + OFF_W
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [P1_W-1:0]  p1_o,
  output logic [P2_W-1:0]  p2_o,
  output logic [OFF_W-1:0] off_o
);
  assign p1_o  = va_i[VA_W-1 -: P1_W];
  assign p2_o  = va_i[OFF_W +: P2_W];
  assign off_o = va_i[OFF_W-1:0];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        l1_valid_i,
  output walk_state_e state_o,
  output logic        accept_o,
  output logic        l1_fault_o
);
  walk_state_e state_q, state_d;
  logic        l1_fault_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_READ_L1;
      ST_READ_L1: state_d = ST_READ_L2;
      ST_READ_L2: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      l1_fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o)                  l1_fault_q <= 1'b0;
      else if (state_q == ST_READ_L2) l1_fault_q <= !l1_valid_i;
    end
  end

  assign state_o    = state_q;
  assign l1_fault_o = l1_fault_q;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int P1_W   = 4,
  parameter int P2_W   = 6,
  parameter int ADDR_W = 12
) (
  input  walk_state_e       state_i,
  input  logic [ADDR_W-1:0] ptbr_i,
  input  logic [P1_W-1:0]   p1_i,
  input  logic [P2_W-1:0]   p2_i,
  input  logic [ADDR_W-1:0] l2_base_i,
  input  logic              l1_valid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] l1_addr, l2_addr;

  // both adders wrap modulo 2^ADDR_W
  assign l1_addr = ptbr_i + ADDR_W'(p1_i);
  assign l2_addr = l2_base_i + ADDR_W'(p2_i);

  always_comb begin
    req_o  = 1'b0;
    addr_o = '0;
    case (state_i)
      ST_READ_L1: begin
        req_o  = 1'b1;
        addr_o = l1_addr;
      end
      ST_READ_L2: begin
        req_o  = l1_valid_i;
        addr_o = l1_valid_i ? l2_addr : '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 16,
  parameter int FRAME_W = 6,
  parameter int OFF_W   = 10,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  walk_state_e        state_i,
  input  logic               l1_fault_i,
  input  logic [ENTRY_W-1:0] l2_entry_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic               done_o,
  output logic               fault_o,
  output logic               fault_lvl_o,
  output logic [PA_W-1:0]    paddr_o
);
  logic unused_entry;
  assign unused_entry = ^l2_entry_i[ENTRY_W-2:FRAME_W];

  always_comb begin
    done_o      = 1'b0;
    fault_o     = 1'b0;
    fault_lvl_o = 1'b0;
    paddr_o     = '0;
    if (state_i == ST_DONE) begin
      done_o = 1'b1;
      if (l1_fault_i) begin
        fault_o = 1'b1;
      end else if (!l2_entry_i[ENTRY_W-1]) begin
        fault_o     = 1'b1;
        fault_lvl_o = 1'b1;
      end else begin
        paddr_o = {l2_entry_i[FRAME_W-1:0], off_i};
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int P1_W    = 4,
  parameter int P2_W    = 6,
  parameter int OFF_W   = 10,
  parameter int ADDR_W  = 12,
  parameter int ENTRY_W = 16,
  parameter int FRAME_W = 6,
  localparam int VA_W   = P1_W + P2_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [ADDR_W-1:0]  ptbr_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               done_o,
  output logic               fault_o,
  output logic               fault_lvl_o,
  output logic [PA_W-1:0]    paddr_o
);
  walk_state_e       state;
  logic              accept, l1_fault;
  logic [VA_W-1:0]   va_q;
  logic [ADDR_W-1:0] ptbr_q;
  logic [P1_W-1:0]   p1;
  logic [P2_W-1:0]   p2;
  logic [OFF_W-1:0]  off;
  logic              entry_valid;

  assign entry_valid = mem_rdata_i[ENTRY_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q   <= '0;
      ptbr_q <= '0;
    end else if (accept) begin
      va_q   <= vaddr_i;
      ptbr_q <= ptbr_i;
    end
  end

  ptw_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .l1_valid_i (entry_valid),
    .state_o    (state),
    .accept_o   (accept),
    .l1_fault_o (l1_fault)
  );

  ptw_va_split #(.P1_W(P1_W), .P2_W(P2_W), .OFF_W(OFF_W)) u_split (
    .va_i  (va_q),
    .p1_o  (p1),
    .p2_o  (p2),
    .off_o (off)
  );

  ptw_addr_gen #(.P1_W(P1_W), .P2_W(P2_W), .ADDR_W(ADDR_W)) u_agen (
    .state_i    (state),
    .ptbr_i     (ptbr_q),
    .p1_i       (p1),
    .p2_i       (p2),
    .l2_base_i  (mem_rdata_i[ADDR_W-1:0]),
    .l1_valid_i (entry_valid),
    .req_o      (mem_req_o),
    .addr_o     (mem_addr_o)
  );

  ptw_result #(.ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_res (
    .state_i     (state),
    .l1_fault_i  (l1_fault),
    .l2_entry_i  (mem_rdata_i),
    .off_i       (off),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_lvl_o (fault_lvl_o),
    .paddr_o     (paddr_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            done_o,
  input logic            fault_o,
  input logic            fault_lvl_o,
  input logic [PA_W-1:0] paddr_o
);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_read_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  p_done_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_walk_not_cut_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_l1_fault_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o && !fault_lvl_o) |-> !$past(mem_req_o));
  p_quiet_outputs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!fault_o && !fault_lvl_o && paddr_o == '0));
  p_fault_pa_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> paddr_o == '0);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .fault_lvl_o (fault_lvl_o),
  .paddr_o     (paddr_o)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int P1_W = 4, P2_W = 6, OFF_W = 10;
  localparam int ADDR_W = 12, ENTRY_W = 16, FRAME_W = 6;
  localparam int VA_W = P1_W + P2_W + OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               start = 1'b0;
  logic [VA_W-1:0]    vaddr = '0;
  logic [ADDR_W-1:0]  ptbr = '0;
  logic               busy, mem_req, done, fault, fault_lvl;
  logic [ADDR_W-1:0]  mem_addr;
  logic [ENTRY_W-1:0] mem_rdata = '0;
  logic [PA_W-1:0]    paddr;
  logic [ENTRY_W-1:0] mem [DEPTH];

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vaddr_i(vaddr), .ptbr_i(ptbr),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_lvl_o(fault_lvl), .paddr_o(paddr)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] l1_addr(input logic [VA_W-1:0] va, input logic [ADDR_W-1:0] b);
    return b + ADDR_W'(va[VA_W-1 -: P1_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] l2_addr(input logic [VA_W-1:0] va, input logic [ENTRY_W-1:0] e);
    return e[ADDR_W-1:0] + ADDR_W'(va[OFF_W +: P2_W]);
  endfunction

  task automatic walk(input logic [VA_W-1:0] va, input logic [ADDR_W-1:0] b, input bit noisy);
    logic [ADDR_W-1:0]  a1, a2;
    logic [ENTRY_W-1:0] e1, e2;
    logic               v1, v2;
    a1 = l1_addr(va, b);
    e1 = mem[a1];
    v1 = e1[ENTRY_W-1];
    a2 = l2_addr(va, e1);
    e2 = mem[a2];
    v2 = e2[ENTRY_W-1];
    @(negedge clk);
    start = 1'b1; vaddr = va; ptbr = b;
    @(negedge clk);  // first cycle after acceptance
    if (noisy) begin vaddr = ~va; ptbr = ~b; end else start = 1'b0;
    chk("R8", "busy in first cycle", busy, 1);
    chk("R2", "first read request", mem_req, 1);
    chk("R2", "first read address", mem_addr, a1);
    chk("R9", "idle outputs quiet", {done, fault, paddr}, 0);
    @(negedge clk);
    if (v1) begin
      chk("R3", "second read request", mem_req, 1);
      chk("R3", "second read address", mem_addr, a2);
    end else begin
      chk("R4", "no second read", mem_req, 0);
    end
    chk("R6", "done not early", done, 0);
    @(negedge clk);
    start = 1'b0;
    chk("R6", "done in third cycle", done, 1);
    chk("R8", "busy in done cycle", busy, 1);
    if (!v1) begin
      chk("R4", "first-level fault", {fault, fault_lvl}, 2'b10);
      chk("R9", "pa zero on fault", paddr, 0);
    end else if (!v2) begin
      chk("R5", "second-level fault", {fault, fault_lvl}, 2'b11);
      chk("R9", "pa zero on fault", paddr, 0);
    end else begin
      chk(noisy ? "R7" : "R9", "physical address", {fault, paddr},
          {1'b0, e2[FRAME_W-1:0], va[OFF_W-1:0]});
    end
    @(negedge clk);
    chk("R6", "single pulse then idle", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {busy, mem_req, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", {busy, mem_req, done}, 0);

    // both adders wrap, largest frame and offset
    mem[12'h00E] = 16'h8FFA;
    mem[12'h039] = 16'h803F;
    walk(20'hFFFFF, 12'hFFF, 1'b0);
    // fault at first level
    mem[12'h105] = 16'h7123;
    walk({4'h5, 6'h01, 10'h155}, 12'h100, 1'b0);
    // fault at second level
    mem[12'h203] = 16'h8400;
    mem[12'h40A] = 16'h003F;
    walk({4'h3, 6'h0A, 10'h2AA}, 12'h200, 1'b0);
    // start and inputs toggling while busy
    mem[12'h302] = 16'h8500;
    mem[12'h511] = 16'h8015;
    walk({4'h2, 6'h11, 10'h0C3}, 12'h300, 1'b1);

    for (int i = 0; i < DEPTH; i++) mem[i] = ENTRY_W'($urandom);
    for (int n = 0; n < 400; n++)
      walk(VA_W'($urandom), ADDR_W'($urandom), n[2]);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule